// File: doc/BRIEF.md
# Single-Cycle 32-bit Subset Processor

This block is a 32-bit processor that finishes every instruction in one clock cycle. It implements nine instructions: word load and store, five register-to-register operations (add, subtract, AND, OR, signed set-on-less-than), branch-on-equal and an unconditional jump. It holds its own program counter, a register file of 32 words, an opcode decoder, an ALU-function decoder, a sign extender, the branch and jump target adders, and two small word-addressed memories, one for instructions and one for data.

The memories have no reset. They are filled through a load port, and that port writes only while the core is held in reset. After reset is released, the core starts fetching at address 0. Each register write and each store is shown on the output ports in the cycle that performs it, so a bench can follow the program as it runs.

Top module: `sc_core`

## Requirements
- R1: While rst_n is low, pc_o is 0, and wb_en and st_en are 0. After release, every cycle that holds no taken branch and no jump ends with the PC raised by 4.
- R2: An instruction with opcode 0x00 writes rs op rt to register rd in the same cycle. The funct field picks the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR. wb_reg carries rd and wb_data carries the result.
- R3: Funct 0x2A with opcode 0x00 writes 1 to rd when rs is less than rt as signed numbers, and 0 otherwise.
- R4: Opcode 0x23 forms the byte address rs + sign-extended imm16. It reads the data word at index address[7:2] and writes that word to register rt.
- R5: Opcode 0x2B raises st_en, drives st_addr with rs + sign-extended imm16 and st_data with rt, and writes that word into data memory. A store causes no register write (wb_en is 0).
- R6: Opcode 0x04 compares rs with rt. If they are equal, the next PC is PC+4 plus the sign-extended imm16 shifted left by 2, which also covers negative offsets. If they differ, the next PC is PC+4.
- R7: Opcode 0x02 sets the next PC to bits 31:28 of PC+4, then bits 25:0 of the instruction, then two zero bits.
- R8: Register 0 always reads as 0. A write whose destination is register 0 is dropped and shows wb_en at 0.
- R9: The load port writes a word only while rst_n is low. ld_sel=0 selects instruction memory and ld_sel=1 selects data memory, and ld_addr is the word index. While the core runs, ld_en has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state element updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; also enables the load port |
| ld_en | input | 1 | Load strobe for one memory word |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | 6 | Word index of the word to load |
| ld_data | input | 32 | Word to load |
| pc_o | output | 32 | Address of the instruction running in this cycle |
| wb_en | output | 1 | A register write happens at the end of this cycle |
| wb_reg | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value written |
| st_en | output | 1 | A data-memory store happens at the end of this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word stored |

## Verification
The assertions assume that every fetched word is one of the nine supported instructions and that every load or store address is word-aligned and falls inside the 64-word data memory. With an undefined opcode the decoder and the next-PC checks would have no defined meaning. The bench preloads every word of both memories during reset, so no fetch or load ever returns an unwritten location. The program uses only subset instructions, keeps its addresses in range, and ends in a self-branch that stays inside instruction memory.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN  = 32;
  localparam int NREGS = 32;

  localparam logic [5:0] OPC_ALU  = 6'h00;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;
  localparam logic [5:0] OPC_BREQ = 6'h04;
  localparam logic [5:0] OPC_JUMP = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    AOP_AND = 4'b0000,
    AOP_OR  = 4'b0001,
    AOP_ADD = 4'b0010,
    AOP_SUB = 4'b0110,
    AOP_SLT = 4'b0111
  } aop_e;

  typedef enum logic [1:0] {
    ACL_ADD  = 2'b00,
    ACL_SUB  = 2'b01,
    ACL_FUNC = 2'b10
  } acl_e;

  typedef struct packed {
    logic dst_rd;
    logic use_imm;
    logic wb_mem;
    logic rwr;
    logic mrd;
    logic mwr;
    logic brq;
    logic jmp;
    acl_e acl;
  } ctl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input aop_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      AOP_AND: r = a & b;
      AOP_OR:  r = a | b;
      AOP_ADD: r = a + b;
      AOP_SUB: r = a - b;
      AOP_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = a + b;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] seq,
                                                  input logic [15:0] off);
    logic [XLEN-1:0] ext;
    ext = sext16(off);
    return seq + {ext[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] seq,
                                                input logic [25:0] idx);
    return {seq[XLEN-1:XLEN-4], idx, 2'b00};
  endfunction
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opc,
  input  logic [5:0] fn,
  output ctl_t       ctl,
  output aop_e       aop
);
  always_comb begin
    ctl = '0;
    ctl.acl = ACL_ADD;
    case (opc)
      OPC_ALU: begin
        ctl.dst_rd = 1'b1;
        ctl.rwr    = 1'b1;
        ctl.acl    = ACL_FUNC;
      end
      OPC_LOAD: begin
        ctl.use_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
        ctl.rwr     = 1'b1;
        ctl.mrd     = 1'b1;
      end
      OPC_STOR: begin
        ctl.use_imm = 1'b1;
        ctl.mwr     = 1'b1;
      end
      OPC_BREQ: begin
        ctl.brq = 1'b1;
        ctl.acl = ACL_SUB;
      end
      OPC_JUMP: ctl.jmp = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (ctl.acl)
      ACL_SUB: aop = AOP_SUB;
      ACL_FUNC: begin
        case (fn)
          FN_SUB:  aop = AOP_SUB;
          FN_AND:  aop = AOP_AND;
          FN_OR:   aop = AOP_OR;
          FN_SLT:  aop = AOP_SLT;
          default: aop = AOP_ADD;
        endcase
      end
      default: aop = AOP_ADD;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int N = 32,
  parameter int W = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign qa = (ra == '0) ? '0 : regs[ra];
  assign qb = (rb == '0) ? '0 : regs[rb];

  // R8
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> wa != '0);
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int WORDS = 64,
  parameter int W = 32,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_idx,
  input  logic [W-1:0]  ld_wd,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd
);
  logic [W-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (ld_we)   cells[ld_idx] <= ld_wd;
    else if (we) cells[idx]    <= wd;
  end

  assign rd = cells[idx];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IWORDS = 64,
  parameter int DWORDS = 64,
  localparam int IAW = $clog2(IWORDS),
  localparam int DAW = $clog2(DWORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic            ld_sel,
  input  logic [IAW-1:0]  ld_addr,
  input  logic [31:0]     ld_data,
  output logic [31:0]     pc_o,
  output logic            wb_en,
  output logic [4:0]      wb_reg,
  output logic [31:0]     wb_data,
  output logic            st_en,
  output logic [31:0]     st_addr,
  output logic [31:0]     st_data
);
  logic [XLEN-1:0] pc, pc_seq, pc_nxt, instr;
  logic [XLEN-1:0] a_val, b_val, alu_b, alu_y, imm_x, mem_q;
  logic [4:0]      dest;
  logic            alu_zero, br_take, load_win;
  ctl_t            ctl;
  aop_e            aop;

  // Load port windows: only while reset is held
  assign load_win = ld_en & ~rst_n;

  sc_mem #(.WORDS(IWORDS), .W(XLEN)) u_imem (
    .clk(clk), .ld_we(load_win & ~ld_sel), .ld_idx(ld_addr), .ld_wd(ld_data),
    .we(1'b0), .idx(pc[IAW+1:2]), .wd('0), .rd(instr)
  );

  sc_ctrl u_ctrl (.opc(instr[31:26]), .fn(instr[5:0]), .ctl(ctl), .aop(aop));

  sc_regfile #(.N(NREGS), .W(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra(instr[25:21]), .rb(instr[20:16]), .qa(a_val), .qb(b_val),
    .we(wb_en), .wa(dest), .wd(wb_data)
  );

  assign imm_x    = sext16(instr[15:0]);
  assign alu_b    = ctl.use_imm ? imm_x : b_val;
  assign alu_y    = alu_eval(aop, a_val, alu_b);
  assign alu_zero = (alu_y == '0);

  sc_mem #(.WORDS(DWORDS), .W(XLEN)) u_dmem (
    .clk(clk), .ld_we(load_win & ld_sel), .ld_idx(ld_addr[DAW-1:0]), .ld_wd(ld_data),
    .we(st_en), .idx(alu_y[DAW+1:2]), .wd(b_val), .rd(mem_q)
  );

  assign dest    = ctl.dst_rd ? instr[15:11] : instr[20:16];
  assign wb_en   = ctl.rwr & (dest != 5'd0) & rst_n;
  assign wb_reg  = dest;
  assign wb_data = ctl.wb_mem ? mem_q : alu_y;
  assign st_en   = ctl.mwr & rst_n;
  assign st_addr = alu_y;
  assign st_data = b_val;

  assign pc_seq  = pc + 32'd4;
  assign br_take = ctl.brq & alu_zero;
  always_comb begin
    if (ctl.jmp)      pc_nxt = jump_dest(pc_seq, instr[25:0]);
    else if (br_take) pc_nxt = branch_dest(pc_seq, instr[15:0]);
    else              pc_nxt = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_nxt;
  end
  assign pc_o = pc;

  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_take && !ctl.jmp) |=> pc == $past(pc) + 32'd4);
  // R6
  beq_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> pc == $past(pc) + 32'd4 + {$past(imm_x[29:0]), 2'b00});
  // R7
  jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.jmp |=> (pc[31:28] == $past(pc_seq[31:28])) && (pc[1:0] == 2'b00));
  // R5
  store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> !wb_en);
  // R4
  load_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.mrd |-> ctl.rwr && !ctl.dst_rd && !st_en);
  // R6
  flow_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.brq, ctl.jmp, ctl.mwr, ctl.rwr}));
endmodule

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic        ld_sel = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, wb_data, st_addr, st_data;
  logic        wb_en, st_en;
  logic [4:0]  wb_reg;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sc_core uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .pc_o(pc_o), .wb_en(wb_en), .wb_reg(wb_reg),
    .wb_data(wb_data), .st_en(st_en), .st_addr(st_addr), .st_data(st_data)
  );

  logic [31:0] im [64];
  logic [31:0] dm [64];
  logic [31:0] rf [32];
  logic [31:0] m_pc;

  function automatic logic [31:0] enc_r(input int fnc, input int s, input int t, input int d);
    return {6'h00, s[4:0], t[4:0], d[4:0], 5'd0, fnc[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(input int opc, input int s, input int t, input int imm);
    return {opc[5:0], s[4:0], t[4:0], imm[15:0]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Reference step: compare outputs with the ISA rules, then commit
  task automatic model_step();
    logic [31:0] ins, a, b, sx, seq, res, nxt;
    logic [5:0]  opc, fnc;
    logic [4:0]  d;
    bit          wr, st;
    string       tg, ptg;
    ins = im[m_pc[7:2]];
    opc = ins[31:26]; fnc = ins[5:0];
    a = (ins[25:21] == 0) ? 32'd0 : rf[ins[25:21]];
    b = (ins[20:16] == 0) ? 32'd0 : rf[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]};
    seq = m_pc + 4; nxt = seq; wr = 0; st = 0; d = 0; res = 0;
    tg = "R2"; ptg = "R1";
    case (opc)
      6'h00: begin
        wr = 1; d = ins[15:11];
        case (fnc)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: begin res = ($signed(a) < $signed(b)) ? 1 : 0; tg = "R3"; end
          default: res = a + b;
        endcase
      end
      6'h23: begin wr = 1; d = ins[20:16]; res = dm[(a + sx) >> 2 & 32'h3F]; tg = "R4"; end
      6'h2B: begin st = 1; res = a + sx; end
      6'h04: begin ptg = "R6"; if (a == b) nxt = seq + (sx << 2); end
      6'h02: begin ptg = "R7"; nxt = {seq[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    if (wr && d == 0) tg = "R8";
    chk(ptg, "pc", pc_o, m_pc);
    chk(tg, "wb_en", {31'd0, wb_en}, {31'd0, (wr && d != 0)});
    if (wr && d != 0) begin
      chk(tg, "wb_reg", {27'd0, wb_reg}, {27'd0, d});
      chk(tg, "wb_data", wb_data, res);
      rf[d] = res;
    end
    chk("R5", "st_en", {31'd0, st_en}, {31'd0, st});
    if (st) begin
      chk("R5", "st_addr", st_addr, res);
      chk("R5", "st_data", st_data, b);
      dm[res[7:2]] = b;
      chk("R5", "store_no_wb", {31'd0, wb_en}, 32'd0);
    end
    m_pc = nxt;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      im[i] = 32'd0;
      dm[i] = 32'h1000_0000 + i;
    end
    for (int i = 0; i < 32; i++) rf[i] = 32'd0;
    dm[0] = 32'd5; dm[1] = 32'hFFFF_FFFD; dm[3] = 32'h0000_1234;
    im[0]  = enc_i(6'h23, 0, 1, 0);
    im[1]  = enc_i(6'h23, 0, 2, 4);
    im[2]  = enc_r(6'h20, 1, 2, 3);
    im[3]  = enc_r(6'h22, 1, 2, 4);
    im[4]  = enc_r(6'h24, 1, 2, 5);
    im[5]  = enc_r(6'h25, 1, 2, 6);
    im[6]  = enc_r(6'h2A, 2, 1, 7);
    im[7]  = enc_r(6'h2A, 1, 2, 8);
    im[8]  = enc_i(6'h2B, 0, 4, 8);
    im[9]  = enc_i(6'h23, 0, 9, 8);
    im[10] = enc_r(6'h20, 1, 1, 0);
    im[11] = enc_r(6'h20, 0, 0, 10);
    im[12] = enc_i(6'h04, 1, 2, 5);
    im[13] = enc_i(6'h04, 9, 4, 2);
    im[14] = enc_r(6'h20, 1, 1, 11);
    im[15] = enc_r(6'h20, 1, 1, 11);
    im[16] = enc_r(6'h20, 9, 9, 14);
    im[17] = enc_i(6'h23, 14, 12, 16'hFFFC);
    im[18] = {6'h02, 26'd20};
    im[19] = enc_r(6'h20, 1, 1, 11);
    im[20] = enc_i(6'h04, 0, 0, 1);
    im[21] = enc_r(6'h20, 1, 1, 11);
    im[22] = enc_i(6'h04, 0, 0, 16'hFFFF);

    // R9: preload both memories while reset is held
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_sel = (i >= 64); ld_addr = i[5:0];
      ld_data = (i >= 64) ? dm[i - 64] : im[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    #1;
    // R1: reset state
    chk("R1", "reset pc", pc_o, 32'd0);
    chk("R1", "reset wb_en", {31'd0, wb_en}, 32'd0);
    chk("R1", "reset st_en", {31'd0, st_en}, 32'd0);

    m_pc = 32'd0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    model_step();
    for (int c = 0; c < 30; c++) begin
      @(negedge clk); #1;
      model_step();
    end

    // R9: load strobes while running must not alter instruction memory
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 1'b0; ld_addr = 6'd22; ld_data = enc_r(6'h20, 1, 1, 11);
    #1;
    model_step();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      model_step();
    end
    @(negedge clk);
    ld_en = 1'b0;
    #1;
    model_step();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #1;
      chk("R9", "pc held in self-branch", pc_o, 32'd88);
      chk("R9", "no write from ignored load", {31'd0, wb_en}, 32'd0);
      model_step();
    end
    finish_run();
  end
endmodule